// File: doc/BRIEF.md
# Decoupled Branch Target Buffer

This block is a small cache that remembers where taken branches went. Each entry pairs the address of a branch (held as a tag and a set index) with the address it jumped to. The fetch stage looks the buffer up in the same cycle it consults a separate direction predictor. The lookup is purely combinational, so it completes within that cycle. The fetch stage is redirected to the stored target only when two things hold at once: the direction predictor says taken, and the buffer holds an entry for the fetch address. In every other case the next fetch address is the current one plus four.

On a miss the buffer cannot supply a target. It therefore reports a static hint instead: a branch marked as backward should be treated as taken, and a forward branch as not taken. Acting on that hint needs a decoded target, so the hint is left to the decoder downstream.

The backend writes to the buffer once a branch has resolved, and only when it resolved taken. A taken branch that is already present has its target rewritten in place. A taken branch that is absent is allocated into its set. An empty way is filled first. When both ways are full, the way written least recently is replaced, which is tracked with one bit per set. A not-taken resolution writes nothing. Reset clears every valid bit.

The next-address choice is made from two named sources. SEQ selects the fetch address plus four. TARGET selects the stored target, and it is chosen only on a hit together with a taken direction.

Top module: `btb_decoupled`

## Requirements
- R1: After reset every entry is invalid. No fetch address hits, and the next address is the fetch address plus four.
- R2: When the lookup hits and f_dir_taken is 1, f_redirect is 1 and f_next_pc equals the stored target.
- R3: When no redirect occurs (a miss, or f_dir_taken is 0), f_redirect is 0 and f_next_pc is f_pc + 4.
- R4: An update with u_taken = 0 changes nothing. It neither allocates a new branch nor alters the target of a branch already present.
- R5: A taken update whose address is already present rewrites that entry's target in place. The other way of the set keeps its contents.
- R6: A taken update that misses allocates into its set. The set index is address bits [IDX_W+1:2] and the tag is the bits above them. An invalid way 0 is chosen first, then an invalid way 1, then the recency victim.
- R7: f_static_taken equals (not hit) AND f_backward. It is never 1 on a hit.
- R8: Every taken write marks its way as most recent. The next victim of that set is the other way.
- R9: An update is seen by lookups from the cycle after the clock edge that accepts it. A lookup in the same cycle sees the old contents.
- R10: A hit requires the full tag to match. Addresses that share a set but differ in any tag bit do not alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears all valid bits and recency bits |
| f_pc | input | PC_W | Current fetch address |
| f_dir_taken | input | 1 | Taken prediction from the direction predictor |
| f_backward | input | 1 | Hint that the fetched branch jumps backward |
| f_next_pc | output | PC_W | Next fetch address |
| f_redirect | output | 1 | Next address comes from the buffer |
| f_hit | output | 1 | Fetch address is present in the buffer |
| f_static_taken | output | 1 | Miss fallback hint: treat the branch as taken |
| u_valid | input | 1 | Backend resolution is present this cycle |
| u_pc | input | PC_W | Address of the resolved branch |
| u_taken | input | 1 | Resolved direction (1 = taken) |
| u_target | input | PC_W | Resolved target address |

## Verification
A fetch lookup and a backend write can land in the same cycle, either on the same set or on the same branch. The bench provokes this by driving an allocation for an address while also presenting that address on the fetch port. It judges the outcome by requiring a miss and sequential next address in that cycle, then a redirect to the new target in the following cycle. The same collision recurs throughout a pseudo-random sweep of a four-set configuration, where a reference model updated only after each comparison fixes which contents the lookup must see.

// File: rtl/btb_pkg.sv
package btb_pkg;

    localparam int DEF_PC_W     = 32;
    localparam int DEF_NUM_SETS = 128;
    localparam int NUM_WAYS     = 2;

    typedef enum logic {
        NXT_SEQ    = 1'b0,
        NXT_TARGET = 1'b1
    } next_src_e;

endpackage

// File: rtl/btb_way.sv
module btb_way #(
    parameter int PC_W     = 32,
    parameter int NUM_SETS = 128,
    localparam int IDX_W   = $clog2(NUM_SETS),
    localparam int TAG_W   = PC_W - IDX_W - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    output logic [PC_W-1:0]  rd_target,
    input  logic [IDX_W-1:0] up_idx,
    input  logic [TAG_W-1:0] up_tag,
    output logic             up_hit,
    output logic             up_valid,
    input  logic             wr_en,
    input  logic [PC_W-1:0]  wr_target
);

    logic [NUM_SETS-1:0] valid_q;
    logic [TAG_W-1:0]    tag_mem [NUM_SETS];
    logic [PC_W-1:0]     tgt_mem [NUM_SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[up_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[up_idx] <= up_tag;
            tgt_mem[up_idx] <= wr_target;
        end
    end

    always_comb begin
        rd_hit    = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
        rd_target = tgt_mem[rd_idx];
        up_valid  = valid_q[up_idx];
        up_hit    = valid_q[up_idx] && (tag_mem[up_idx] == up_tag);
    end

endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
    parameter int NUM_SETS = 128,
    localparam int IDX_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch,
    input  logic             touched_way,
    output logic             victim_way
);

    logic [NUM_SETS-1:0] victim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_q <= '0;
        end else if (touch) begin
            victim_q[idx] <= ~touched_way;
        end
    end

    always_comb begin
        victim_way = victim_q[idx];
    end

endmodule

// File: rtl/btb_select.sv
module btb_select
    import btb_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic [PC_W-1:0] pc,
    input  logic            hit,
    input  logic [PC_W-1:0] hit_target,
    input  logic            dir_taken,
    input  logic            backward,
    output logic [PC_W-1:0] next_pc,
    output logic            redirect,
    output logic            static_taken
);

    next_src_e src;

    always_comb begin
        src = (dir_taken && hit) ? NXT_TARGET : NXT_SEQ;
    end

    always_comb begin
        unique case (src)
            NXT_SEQ: begin
                next_pc  = pc + PC_W'(4);
                redirect = 1'b0;
            end
            NXT_TARGET: begin
                next_pc  = hit_target;
                redirect = 1'b1;
            end
        endcase
        static_taken = !hit && backward;
    end

endmodule

// File: rtl/btb_decoupled.sv
module btb_decoupled
    import btb_pkg::*;
#(
    parameter int PC_W     = DEF_PC_W,
    parameter int NUM_SETS = DEF_NUM_SETS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] f_pc,
    input  logic            f_dir_taken,
    input  logic            f_backward,
    output logic [PC_W-1:0] f_next_pc,
    output logic            f_redirect,
    output logic            f_hit,
    output logic            f_static_taken,
    input  logic            u_valid,
    input  logic [PC_W-1:0] u_pc,
    input  logic            u_taken,
    input  logic [PC_W-1:0] u_target
);

    localparam int IDX_W = $clog2(NUM_SETS);
    localparam int TAG_W = PC_W - IDX_W - 2;

    logic [IDX_W-1:0]    f_idx, u_idx;
    logic [TAG_W-1:0]    f_tag, u_tag;
    logic [NUM_WAYS-1:0] rd_hit, up_hit, up_vld, wr_en;
    logic [PC_W-1:0]     rd_tgt [NUM_WAYS];
    logic [PC_W-1:0]     hit_tgt;
    logic                u_write, victim_way, sel_way;
    logic                unused_u_low;

    assign f_idx        = f_pc[IDX_W+1:2];
    assign f_tag        = f_pc[PC_W-1:IDX_W+2];
    assign u_idx        = u_pc[IDX_W+1:2];
    assign u_tag        = u_pc[PC_W-1:IDX_W+2];
    assign unused_u_low = ^u_pc[1:0];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        btb_way #(
            .PC_W     (PC_W),
            .NUM_SETS (NUM_SETS)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (f_idx),
            .rd_tag    (f_tag),
            .rd_hit    (rd_hit[w]),
            .rd_target (rd_tgt[w]),
            .up_idx    (u_idx),
            .up_tag    (u_tag),
            .up_hit    (up_hit[w]),
            .up_valid  (up_vld[w]),
            .wr_en     (wr_en[w]),
            .wr_target (u_target)
        );
    end

    // Way choice for a taken write: present entry, empty way, recency victim
    always_comb begin
        u_write = u_valid && u_taken;
        if (up_hit[1])       sel_way = 1'b1;
        else if (up_hit[0])  sel_way = 1'b0;
        else if (!up_vld[0]) sel_way = 1'b0;
        else if (!up_vld[1]) sel_way = 1'b1;
        else                 sel_way = victim_way;
        wr_en[0] = u_write && !sel_way;
        wr_en[1] = u_write &&  sel_way;
    end

    btb_lru #(
        .NUM_SETS (NUM_SETS)
    ) u_lru (
        .clk         (clk),
        .rst_n       (rst_n),
        .idx         (u_idx),
        .touch       (u_write),
        .touched_way (sel_way),
        .victim_way  (victim_way)
    );

    always_comb begin
        f_hit   = |rd_hit;
        hit_tgt = rd_hit[1] ? rd_tgt[1] : rd_tgt[0];
    end

    btb_select #(
        .PC_W (PC_W)
    ) u_select (
        .pc           (f_pc),
        .hit          (f_hit),
        .hit_target   (hit_tgt),
        .dir_taken    (f_dir_taken),
        .backward     (f_backward),
        .next_pc      (f_next_pc),
        .redirect     (f_redirect),
        .static_taken (f_static_taken)
    );

endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
    parameter int PC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] f_pc,
    input logic            f_dir_taken,
    input logic            f_backward,
    input logic [PC_W-1:0] f_next_pc,
    input logic            f_redirect,
    input logic            f_hit,
    input logic            f_static_taken,
    input logic            u_valid,
    input logic [PC_W-1:0] u_pc,
    input logic            u_taken,
    input logic [PC_W-1:0] u_target
);

    // R2: a redirect needs both a hit and a taken direction
    a_r2_redirect_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        f_redirect |-> (f_hit && f_dir_taken));

    // R3: without a redirect the next address is sequential
    a_r3_sequential_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        !f_redirect |-> (f_next_pc == f_pc + PC_W'(4)));

    // R7: the static hint only appears on a miss, and follows the backward hint
    a_r7_hint_on_miss_only: assert property (@(posedge clk) disable iff (!rst_n)
        f_static_taken |-> (!f_hit && f_backward));

    // R5 / R9: a taken write is visible to the next cycle's lookup of that address
    a_r5_write_visible_next: assert property (@(posedge clk) disable iff (!rst_n)
        (u_valid && u_taken) |=>
            ((f_pc[PC_W-1:2] != $past(u_pc[PC_W-1:2])) || !f_dir_taken ||
             (f_redirect && (f_next_pc == $past(u_target)))));

endmodule

bind btb_decoupled btb_checker #(.PC_W(PC_W)) u_btb_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .f_pc           (f_pc),
    .f_dir_taken    (f_dir_taken),
    .f_backward     (f_backward),
    .f_next_pc      (f_next_pc),
    .f_redirect     (f_redirect),
    .f_hit          (f_hit),
    .f_static_taken (f_static_taken),
    .u_valid        (u_valid),
    .u_pc           (u_pc),
    .u_taken        (u_taken),
    .u_target       (u_target)
);

// File: tb/btb_decoupled_bench.sv
module btb_decoupled_bench;

    localparam int PC_W = 32;
    localparam int SETS = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] f_pc = '0;
    logic            f_dir_taken = 1'b0;
    logic            f_backward = 1'b0;
    logic [PC_W-1:0] f_next_pc;
    logic            f_redirect;
    logic            f_hit;
    logic            f_static_taken;
    logic            u_valid = 1'b0;
    logic [PC_W-1:0] u_pc = '0;
    logic            u_taken = 1'b0;
    logic [PC_W-1:0] u_target = '0;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model: 4 sets x 2 ways, tag = pc[31:4], index = pc[3:2]
    bit          m_val [SETS][2];
    logic [27:0] m_tag [SETS][2];
    logic [31:0] m_tgt [SETS][2];
    bit          m_vic [SETS];

    always #4 clk = ~clk;

    btb_decoupled #(
        .PC_W     (PC_W),
        .NUM_SETS (SETS)
    ) u_btb_decoupled (
        .clk            (clk),
        .rst_n          (rst_n),
        .f_pc           (f_pc),
        .f_dir_taken    (f_dir_taken),
        .f_backward     (f_backward),
        .f_next_pc      (f_next_pc),
        .f_redirect     (f_redirect),
        .f_hit          (f_hit),
        .f_static_taken (f_static_taken),
        .u_valid        (u_valid),
        .u_pc           (u_pc),
        .u_taken        (u_taken),
        .u_target       (u_target)
    );

    function automatic logic [31:0] mk_pc(input logic [27:0] tg, input logic [1:0] ix);
        return {tg, ix, 2'b00};
    endfunction

    task automatic check_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic check_word(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_write(input logic [31:0] pc, input logic [31:0] tgt);
        int ix;
        int w;
        ix = int'(pc[3:2]);
        w = -1;
        for (int k = 0; k < 2; k++)
            if (m_val[ix][k] && m_tag[ix][k] == pc[31:4]) w = k;
        if (w < 0) begin
            if (!m_val[ix][0])      w = 0;
            else if (!m_val[ix][1]) w = 1;
            else                    w = int'(m_vic[ix]);
        end
        m_val[ix][w] = 1'b1;
        m_tag[ix][w] = pc[31:4];
        m_tgt[ix][w] = tgt;
        m_vic[ix] = (w == 0);
    endtask

    // One cycle: drive at the falling edge, compare before the rising edge,
    // then fold the accepted update into the model
    task automatic step(input string req, input logic [31:0] pc, input logic dir, input logic bwd,
                        input logic uv, input logic [31:0] upc, input logic ut, input logic [31:0] utgt);
        int ix;
        logic hit;
        logic [31:0] tgt;
        logic redir;
        @(negedge clk);
        f_pc = pc; f_dir_taken = dir; f_backward = bwd;
        u_valid = uv; u_pc = upc; u_taken = ut; u_target = utgt;
        #1;
        ix = int'(pc[3:2]);
        hit = 1'b0;
        tgt = '0;
        for (int k = 0; k < 2; k++)
            if (m_val[ix][k] && m_tag[ix][k] == pc[31:4]) begin
                hit = 1'b1;
                tgt = m_tgt[ix][k];
            end
        redir = hit && dir;
        check_bit(req, "hit", f_hit, hit);
        check_bit(req, "redirect", f_redirect, redir);
        check_word(req, "next_pc", f_next_pc, redir ? tgt : pc + 32'd4);
        check_bit(req, "static_taken", f_static_taken, !hit && bwd);
        if (uv && ut) model_write(upc, utgt);
    endtask

    task automatic fetch(input string req, input logic [31:0] pc, input logic dir, input logic bwd);
        step(req, pc, dir, bwd, 1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] lf;
        logic [31:0] pa, pb, px, py, pz;
        for (int s = 0; s < SETS; s++) begin
            m_vic[s] = 1'b0;
            for (int w = 0; w < 2; w++) m_val[s][w] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset, every set and hint combination
        for (int ix = 0; ix < SETS; ix++)
            for (int c = 0; c < 4; c++) begin
                fetch("R1", mk_pc(28'h0000_005, 2'(ix)), c[0], c[1]);
                check_bit("R1", "hit_after_reset", f_hit, 1'b0);
            end

        // R9: allocate and fetch the same address in one cycle
        pa = mk_pc(28'h0000_010, 2'd1);
        step("R9", pa, 1'b1, 1'b0, 1'b1, pa, 1'b1, 32'h0000_4000);
        check_bit("R9", "same_cycle_miss", f_hit, 1'b0);
        // R2: hit with taken direction redirects
        fetch("R2", pa, 1'b1, 1'b0);
        check_word("R2", "target", f_next_pc, 32'h0000_4000);
        // R3: hit but not taken stays sequential; miss with taken stays sequential
        fetch("R3", pa, 1'b0, 1'b0);
        check_word("R3", "seq_on_hit", f_next_pc, pa + 32'd4);
        fetch("R3", mk_pc(28'h0000_011, 2'd1), 1'b1, 1'b0);
        // R7: backward hint on a hit gives no static hint; on a miss it does
        fetch("R7", pa, 1'b1, 1'b1);
        check_bit("R7", "no_hint_on_hit", f_static_taken, 1'b0);
        fetch("R7", mk_pc(28'h0000_012, 2'd1), 1'b0, 1'b1);
        check_bit("R7", "hint_on_miss", f_static_taken, 1'b1);

        // R4: not-taken resolutions change nothing
        pb = mk_pc(28'h0000_020, 2'd1);
        step("R4", pb, 1'b1, 1'b0, 1'b1, pb, 1'b0, 32'h0000_5000);
        step("R4", pa, 1'b1, 1'b0, 1'b1, pa, 1'b0, 32'h0000_6000);
        fetch("R4", pb, 1'b1, 1'b0);
        check_bit("R4", "not_taken_no_alloc", f_hit, 1'b0);
        fetch("R4", pa, 1'b1, 1'b0);
        check_word("R4", "target_kept", f_next_pc, 32'h0000_4000);

        // R5: taken rewrite in place
        step("R5", pa, 1'b0, 1'b0, 1'b1, pa, 1'b1, 32'h0000_7000);
        fetch("R5", pa, 1'b1, 1'b0);
        check_word("R5", "rewritten", f_next_pc, 32'h0000_7000);

        // R6 / R8: fill set 2, refresh X, then Z must evict Y
        px = mk_pc(28'h0000_001, 2'd2);
        py = mk_pc(28'h0000_002, 2'd2);
        pz = mk_pc(28'h0000_003, 2'd2);
        step("R6", px, 1'b0, 1'b0, 1'b1, px, 1'b1, 32'h0000_8000);
        step("R6", py, 1'b0, 1'b0, 1'b1, py, 1'b1, 32'h0000_9000);
        step("R8", px, 1'b1, 1'b0, 1'b1, px, 1'b1, 32'h0000_8000);
        step("R8", pz, 1'b1, 1'b0, 1'b1, pz, 1'b1, 32'h0000_A000);
        fetch("R8", px, 1'b1, 1'b0);
        check_word("R8", "recent_kept", f_next_pc, 32'h0000_8000);
        fetch("R8", py, 1'b1, 1'b0);
        check_bit("R8", "victim_evicted", f_hit, 1'b0);
        fetch("R6", pz, 1'b1, 1'b0);
        check_word("R6", "allocated", f_next_pc, 32'h0000_A000);

        // R10: same set, tag differing in the top bit only
        fetch("R10", px ^ 32'h8000_0000, 1'b1, 1'b0);
        check_bit("R10", "no_alias", f_hit, 1'b0);

        // R6 / R8 / R9: pseudo-random sweep over few tags and all sets
        lf = 32'hACE1_1234;
        for (int n = 0; n < 600; n++) begin
            logic [31:0] fp, up;
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            fp = mk_pc(28'(lf[2:0] % 3'd5), lf[4:3]);
            up = mk_pc(28'(lf[7:5] % 3'd5), lf[9:8]);
            step("R8", fp, lf[10], lf[11], lf[12], up, lf[13], {16'h0, lf[29:14], 2'b00} ^ 32'h0010_0000);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule